// File: doc/BRIEF.md
# Time-Multiplexed I/Q Automatic Gain Control

This block closes a digital gain loop around a complex baseband stream whose I and Q samples share one data input. They arrive one after another, each marked by a valid strobe. For every valid sample the block takes the sample's magnitude and compares it with a programmable target. It then moves a gain accumulator one step up or down. The step size is one unit of gain shifted right by a programmable amount D. The applied gain is the sum of a user-programmed gain word and the accumulator. The block multiplies each incoming sample by that gain and registers the result.

The block has two pairing modes:
- **Shared-gain mode.** I and Q feed a single accumulator.
- **Two-pair mode.** A signal pair and a diversity pair each keep their own accumulator. Samples arrive as signal I, signal Q, diversity I, diversity Q.

Adjustment limits stop the loop from running away. A freeze control holds the loop, and a clear input wipes the accumulators. An optional monitor format packs the upper gain bits and a two-bit loop state into the low bits of each output word.

Gain words are signed, with 2^20 meaning unity. The full 25-bit applied gain of each sample is also presented on its own output, so a frozen or disabled loop can still pass a wide gain value downstream.

Top module: `agc_iq_loop`

## Requirements
- R1: On each valid sample with freeze low and clear low, the accumulator of that sample's pair moves by 2^(20-D), where D is `cfg_shift` (legal range 3 to 18). It moves up when the sample magnitude is below `cfg_target`, down when it is above, and not at all when the two are equal.
- R2: While `in_valid` is low, no accumulator and no slot position changes, and `out_valid` is low on the following cycle.
- R3: With `cfg_dual` low, valid samples alternate between I (slot 0) and Q (slot 1). Both update and use the same accumulator (pair A).
- R4: With `cfg_dual` high, valid samples cycle through slots 0..3 in the order A-I, A-Q, B-I, B-Q. Slots 0 and 1 use accumulator A and slots 2 and 3 use accumulator B. A sample of one pair never changes the other pair's accumulator.
- R5: A step up is skipped while the accumulator is greater than `cfg_amax`. A step down is skipped while the accumulator is less than `cfg_amin`.
- R6: While `cfg_freeze` is high, the accumulators hold their values. The applied gain is then `cfg_user_gain` plus the held accumulator.
- R7: A cycle with `acc_clear` high sets both accumulators to zero, whether or not freeze is high. Afterwards the applied gain equals `cfg_user_gain`.
- R8: One cycle after a valid sample x, `out_valid` is high. `out_data` is then the product of x and the gain G, arithmetically shifted right by 20 and saturated to the signed range -131072..131071. G is the user gain plus the pair's accumulator as it stood before this sample's update. `out_gain` carries G in full (25 bits).
- R9: With `cfg_mon` high, bits 17:10 of the output word hold bits 17:10 of the saturated product. For an I slot, bits 9:2 hold G[18:11] and bits 1:0 hold the loop state. For a Q slot, bits 9:4 hold G[10:5] and bits 3:0 are zero.
- R10: The loop state of the sample's pair, taken before its update, is 11 when freeze is high. Otherwise it is 01 when the accumulator is above `cfg_amax`, 10 when it is below `cfg_amin`, and 00 otherwise. It appears on `out_state` and in the monitor word.
- R11: After reset, both accumulators are zero, the slot position is 0, and `out_valid`, `out_data`, `out_gain` and `out_state` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 18 | Signed input sample, I and Q interleaved |
| cfg_dual | input | 1 | 1 = two-pair mode, 0 = shared-gain mode |
| cfg_shift | input | 5 | Step shift D, 3 to 18 |
| cfg_target | input | 18 | Unsigned magnitude target |
| cfg_user_gain | input | 25 | Signed user gain, 2^20 = unity |
| cfg_amax | input | 25 | Signed upper adjustment limit |
| cfg_amin | input | 25 | Signed lower adjustment limit |
| cfg_freeze | input | 1 | Hold the loop |
| acc_clear | input | 1 | Zero both accumulators |
| cfg_mon | input | 1 | Embed gain and state bits in output words |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 18 | Gain-corrected sample or monitor word |
| out_gain | output | 25 | Gain applied to this output word |
| out_state | output | 2 | Loop state of the pair for this word |

## Verification
The assertions assume several things about the inputs:
- `cfg_amin` does not exceed `cfg_amax`.
- The limits sit far enough inside the 25-bit range that one step past a limit cannot wrap the accumulator.
- `cfg_shift` stays within 3 to 18.

The stimulus keeps to these assumptions. It only uses limits a few steps from zero or around ±4·10^6, and shifts of 4, 6 and 10. It switches the pairing mode only when the slot position is back at 0. It changes configuration only between samples, on the falling edge.

// File: rtl/agc_pkg.sv
package agc_pkg;

  typedef enum logic [1:0] {
    ST_TRACK = 2'b00,
    ST_HIGH  = 2'b01,
    ST_LOW   = 2'b10,
    ST_HOLD  = 2'b11
  } agc_state_e;

endpackage

// File: rtl/agc_slot_seq.sv
module agc_slot_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic dual,
  output logic is_q,
  output logic pair_b
);

  logic [1:0] slot_q;
  logic [1:0] slot_d;

  always_comb begin
    slot_d = slot_q;
    if (adv) begin
      if (dual) slot_d = slot_q + 2'd1;
      else      slot_d = {1'b0, ~slot_q[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= 2'd0;
    else        slot_q <= slot_d;
  end

  assign is_q   = slot_q[0];
  assign pair_b = dual & slot_q[1];

  AST_SINGLE_TWO_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !dual) |=> (slot_q[1] == 1'b0)); // R3

  AST_IDLE_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> (slot_q == $past(slot_q))); // R2

endmodule

// File: rtl/agc_err_det.sv
module agc_err_det #(
  parameter int DATA_W = 18
) (
  input  logic signed [DATA_W-1:0] sample,
  input  logic        [DATA_W-1:0] target,
  output logic                     dir_up,
  output logic                     dir_dn
);

  logic [DATA_W-1:0] mag;

  always_comb begin
    if (sample[DATA_W-1]) mag = DATA_W'(-sample);
    else                  mag = sample;
    dir_up = (mag < target);
    dir_dn = (mag > target);
  end

endmodule

// File: rtl/agc_acc.sv
module agc_acc
  import agc_pkg::*;
#(
  parameter int GAIN_W  = 25,
  parameter int FRAC_W  = 20,
  parameter int SHIFT_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     dir_up,
  input  logic                     dir_dn,
  input  logic                     freeze,
  input  logic                     clear,
  input  logic        [SHIFT_W-1:0] shift,
  input  logic signed [GAIN_W-1:0] amax,
  input  logic signed [GAIN_W-1:0] amin,
  output logic signed [GAIN_W-1:0] acc,
  output agc_state_e               state
);

  localparam logic [GAIN_W-1:0] UNIT = GAIN_W'(1) << FRAC_W;

  logic signed [GAIN_W-1:0] acc_q;
  logic signed [GAIN_W-1:0] acc_d;
  logic signed [GAIN_W-1:0] step;
  logic                     above;
  logic                     below;

  assign step  = signed'(UNIT >> shift);
  assign above = (acc_q > amax);
  assign below = (acc_q < amin);

  always_comb begin
    acc_d = acc_q;
    if (clear) begin
      acc_d = '0;
    end else if (en && !freeze) begin
      if (dir_up && !above)      acc_d = acc_q + step;
      else if (dir_dn && !below) acc_d = acc_q - step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  always_comb begin
    if (freeze)     state = ST_HOLD;
    else if (above) state = ST_HIGH;
    else if (below) state = ST_LOW;
    else            state = ST_TRACK;
  end

  assign acc = acc_q;

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !freeze && !clear) |=>
      ((acc_q == $past(acc_q)) ||
       (acc_q == $past(acc_q) + $past(step)) ||
       (acc_q == $past(acc_q) - $past(step)))); // R1

  AST_EQUAL_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clear && !dir_up && !dir_dn) |=> (acc_q == $past(acc_q))); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clear) |=> (acc_q == $past(acc_q))); // R2

  AST_NO_RISE_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_q > amax) && !clear) |=> (acc_q <= $past(acc_q))); // R5

  AST_NO_FALL_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_q < amin) && !clear) |=> (acc_q >= $past(acc_q))); // R5

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !clear) |=> (acc_q == $past(acc_q))); // R6

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_q == '0)); // R7

endmodule

// File: rtl/agc_apply.sv
module agc_apply #(
  parameter int DATA_W = 18,
  parameter int GAIN_W = 25,
  parameter int FRAC_W = 20
) (
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [GAIN_W-1:0] gain,
  input  logic                     is_q,
  input  logic                     mon,
  input  logic        [1:0]        state,
  output logic        [DATA_W-1:0] word
);

  localparam int PW   = DATA_W + GAIN_W;
  localparam int KEEP = 8;
  localparam logic signed [PW-1:0] SAT_HI = PW'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [PW-1:0] SAT_LO = ~SAT_HI;

  logic        [PW-1:0]     prod_u;
  logic signed [PW-1:0]     scaled;
  logic        [DATA_W-1:0] sat;

  always_comb begin
    prod_u = {{GAIN_W{sample[DATA_W-1]}}, sample} *
             {{DATA_W{gain[GAIN_W-1]}}, gain};
    scaled = signed'(prod_u) >>> FRAC_W;
    if (scaled > SAT_HI)      sat = SAT_HI[DATA_W-1:0];
    else if (scaled < SAT_LO) sat = SAT_LO[DATA_W-1:0];
    else                      sat = scaled[DATA_W-1:0];
  end

  always_comb begin
    if (!mon)      word = sat;
    else if (is_q) word = {sat[DATA_W-1 -: KEEP], gain[10:5], 4'b0000};
    else           word = {sat[DATA_W-1 -: KEEP], gain[18:11], state};
  end

endmodule

// File: rtl/agc_iq_loop.sv
module agc_iq_loop
  import agc_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int GAIN_W  = 25,
  parameter int FRAC_W  = 20,
  parameter int SHIFT_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic                     cfg_dual,
  input  logic        [SHIFT_W-1:0] cfg_shift,
  input  logic        [DATA_W-1:0] cfg_target,
  input  logic signed [GAIN_W-1:0] cfg_user_gain,
  input  logic signed [GAIN_W-1:0] cfg_amax,
  input  logic signed [GAIN_W-1:0] cfg_amin,
  input  logic                     cfg_freeze,
  input  logic                     acc_clear,
  input  logic                     cfg_mon,
  output logic                     out_valid,
  output logic        [DATA_W-1:0] out_data,
  output logic        [GAIN_W-1:0] out_gain,
  output logic        [1:0]        out_state
);

  localparam int NPAIR = 2;

  logic                     is_q;
  logic                     pair_b;
  logic                     dir_up;
  logic                     dir_dn;
  logic signed [GAIN_W-1:0] acc_w [NPAIR];
  agc_state_e               st_w  [NPAIR];
  logic signed [GAIN_W-1:0] gain_sel;
  agc_state_e               st_sel;
  logic        [DATA_W-1:0] word;

  logic                     vld_q,   vld_d;
  logic        [DATA_W-1:0] data_q,  data_d;
  logic        [GAIN_W-1:0] gain_q,  gain_d;
  logic        [1:0]        state_q, state_d;

  agc_slot_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (in_valid),
    .dual   (cfg_dual),
    .is_q   (is_q),
    .pair_b (pair_b)
  );

  agc_err_det #(.DATA_W(DATA_W)) u_err (
    .sample (in_data),
    .target (cfg_target),
    .dir_up (dir_up),
    .dir_dn (dir_dn)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    agc_acc #(
      .GAIN_W  (GAIN_W),
      .FRAC_W  (FRAC_W),
      .SHIFT_W (SHIFT_W)
    ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (in_valid && (pair_b == 1'(p))),
      .dir_up (dir_up),
      .dir_dn (dir_dn),
      .freeze (cfg_freeze),
      .clear  (acc_clear),
      .shift  (cfg_shift),
      .amax   (cfg_amax),
      .amin   (cfg_amin),
      .acc    (acc_w[p]),
      .state  (st_w[p])
    );
  end

  assign gain_sel = cfg_user_gain + acc_w[pair_b];
  assign st_sel   = st_w[pair_b];

  agc_apply #(
    .DATA_W (DATA_W),
    .GAIN_W (GAIN_W),
    .FRAC_W (FRAC_W)
  ) u_apply (
    .sample (in_data),
    .gain   (gain_sel),
    .is_q   (is_q),
    .mon    (cfg_mon),
    .state  (st_sel),
    .word   (word)
  );

  always_comb begin
    vld_d   = in_valid;
    data_d  = data_q;
    gain_d  = gain_q;
    state_d = state_q;
    if (in_valid) begin
      data_d  = word;
      gain_d  = gain_sel;
      state_d = st_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      data_q  <= '0;
      gain_q  <= '0;
      state_q <= 2'b00;
    end else begin
      vld_q   <= vld_d;
      data_q  <= data_d;
      gain_q  <= gain_d;
      state_q <= state_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign out_gain  = gain_q;
  assign out_state = state_q;

  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2

  AST_B_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pair_b && !acc_clear) |=> (acc_w[1] == $past(acc_w[1]))); // R4

  AST_A_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pair_b && !acc_clear) |=> (acc_w[0] == $past(acc_w[0]))); // R4

endmodule

// File: tb/tb_agc_iq_loop.sv
module tb_agc_iq_loop;

  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid;
  logic signed [17:0] in_data;
  logic               cfg_dual;
  logic [4:0]         cfg_shift;
  logic [17:0]        cfg_target;
  logic signed [24:0] cfg_user_gain;
  logic signed [24:0] cfg_amax;
  logic signed [24:0] cfg_amin;
  logic               cfg_freeze;
  logic               acc_clear;
  logic               cfg_mon;
  logic               out_valid;
  logic [17:0]        out_data;
  logic [24:0]        out_gain;
  logic [1:0]         out_state;

  int     n_checks = 0;
  int     n_errors = 0;
  longint accA = 0;
  longint accB = 0;
  int     slot = 0;
  bit     done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agc_iq_loop dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_dual(cfg_dual), .cfg_shift(cfg_shift), .cfg_target(cfg_target),
    .cfg_user_gain(cfg_user_gain), .cfg_amax(cfg_amax), .cfg_amin(cfg_amin),
    .cfg_freeze(cfg_freeze), .acc_clear(acc_clear), .cfg_mon(cfg_mon),
    .out_valid(out_valid), .out_data(out_data), .out_gain(out_gain),
    .out_state(out_state)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic send(input string tag, input int x);
    longint acc, g, sc, st, stepv, mag;
    logic [17:0] expw;
    logic [63:0] gv, sv;
    bit pb, isq;
    pb  = cfg_dual && (slot >= 2);
    isq = (slot % 2) == 1;
    acc = pb ? accB : accA;
    g   = longint'(cfg_user_gain) + acc;
    if (cfg_freeze) st = 3;
    else if (acc > longint'(cfg_amax)) st = 1;
    else if (acc < longint'(cfg_amin)) st = 2;
    else st = 0;
    sc = (longint'(x) * g) >>> 20;
    if (sc > 131071) sc = 131071;
    if (sc < -131072) sc = -131072;
    gv = g; sv = sc;
    if (!cfg_mon) expw = sv[17:0];
    else if (isq) expw = {sv[17:10], gv[10:5], 4'b0000};
    else          expw = {sv[17:10], gv[18:11], 2'(st)};
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 18'(x);
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, "out_valid", longint'(out_valid), 1);
    chk(tag, "out_data", longint'(out_data), longint'(expw));
    chk(tag, "out_gain", longint'(out_gain), longint'(gv[24:0]));
    chk(tag, "out_state", longint'(out_state), st);
    mag   = (x < 0) ? -x : x;
    stepv = (64'sd1 << 20) >>> cfg_shift;
    if (!cfg_freeze) begin
      if (mag < longint'(cfg_target) && !(acc > longint'(cfg_amax))) acc = acc + stepv;
      else if (mag > longint'(cfg_target) && !(acc < longint'(cfg_amin))) acc = acc - stepv;
    end
    if (pb) accB = acc; else accA = acc;
    if (cfg_dual) slot = (slot + 1) % 4;
    else slot = (slot % 2 == 1) ? 0 : 1;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    acc_clear = 1'b1;
    @(negedge clk);
    acc_clear = 1'b0;
    accA = 0;
    accB = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "out_valid", longint'(out_valid), 0);
    chk("R11", "out_data", longint'(out_data), 0);
    chk("R11", "out_gain", longint'(out_gain), 0);
    chk("R11", "out_state", longint'(out_state), 0);
    send("R11", 1000);
  endtask

  task automatic t_single();
    cfg_shift = 5'd6;
    send("R3", 500);
    send("R3", -400);
    send("R3", 700);
    send("R3", -20);
    send("R1", 1000);
    send("R1", -1000);
    send("R1", -3000);
    send("R1", 5000);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_data = 18'(i * 7777);
      chk("R2", "out_valid idle", longint'(out_valid), 0);
    end
    send("R2", 200);
  endtask

  task automatic t_dual();
    if (slot != 0) send("R3", 100);
    cfg_dual  = 1'b1;
    cfg_shift = 5'd10;
    for (int r = 0; r < 3; r++) begin
      send("R4", 100);
      send("R4", -100);
      send("R4", 50000);
      send("R4", -50000);
    end
    cfg_dual = 1'b0;
  endtask

  task automatic t_limits();
    pulse_clear();
    cfg_shift = 5'd4;
    cfg_amax  = 25'sd100000;
    for (int i = 0; i < 6; i++) send("R5", 10);
    chk("R5", "acc at upper stop", accA, 131072);
    cfg_amax   = 25'sd4000000;
    cfg_amin   = -25'sd100000;
    cfg_target = 18'd10;
    pulse_clear();
    for (int i = 0; i < 6; i++) send("R5", 2000);
    cfg_target = 18'd1000;
    cfg_amin   = -25'sd4000000;
  endtask

  task automatic t_freeze();
    cfg_shift = 5'd6;
    send("R6", 10);
    send("R6", 10);
    cfg_freeze = 1'b1;
    for (int i = 0; i < 4; i++) send("R6", 10);
    pulse_clear();
    send("R7", 1234);
    send("R7", -4321);
    cfg_freeze = 1'b0;
  endtask

  task automatic t_mon();
    if (slot != 0) send("R9", 100);
    cfg_mon = 1'b1;
    send("R9", 30000);
    send("R9", -30000);
    send("R10", 64000);
    send("R10", 20);
    cfg_freeze = 1'b1;
    send("R10", 500);
    send("R10", 500);
    cfg_freeze = 1'b0;
    cfg_mon = 1'b0;
  endtask

  task automatic t_sat();
    pulse_clear();
    cfg_freeze    = 1'b1;
    cfg_user_gain = 25'sd8388607;
    send("R8", 100000);
    send("R8", -100000);
    cfg_user_gain = 25'(8 << 20);
    send("R8", 1000);
    send("R8", -1001);
    cfg_freeze    = 1'b0;
    cfg_user_gain = 25'(1 << 20);
  endtask

  initial begin
    rst_n         = 1'b0;
    in_valid      = 1'b0;
    in_data       = '0;
    cfg_dual      = 1'b0;
    cfg_shift     = 5'd6;
    cfg_target    = 18'd1000;
    cfg_user_gain = 25'(1 << 20);
    cfg_amax      = 25'sd4000000;
    cfg_amin      = -25'sd4000000;
    cfg_freeze    = 1'b0;
    acc_clear     = 1'b0;
    cfg_mon       = 1'b0;
    t_reset();
    t_single();
    t_idle();
    t_dual();
    t_limits();
    t_freeze();
    t_mon();
    t_sat();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule